// File: doc/BRIEF.md
# Ring Node Command Frame Handler

This block is the frame processor of one node on a daisy-chained configuration ring. The link layer in front of it delivers each 69-bit frame as a parallel word with a one-cycle valid strobe. The handler decides whether the frame concerns this node and, if so, carries out its command on a simple synchronous local register bus. It then hands a frame downstream to the link layer through a send/ready handshake. The outgoing frame is either the original frame, a forwarded copy with a larger hop count, or a reply that carries the read data.

The handler also owns the bridge-mode flag. That flag tells the link layer to route traffic past this node. The node's own ring address comes in on a port, so the same block serves every position on the ring. The master is at address 0, and the all-ones address reaches every node. While a frame is in progress, the handler takes no new input. This lets the link layer hold off delivery until the previous frame has left the node.

Top module: `ring_frame_node`

## Requirements
- R1: A frame field of width W stored at top bit T keeps its bit i at frame bit T-i. The fields are: node address (7 bits, T=68), request flag (bit 61), hop count (8 bits, T=60), command (4 bits, T=52), bus address (16 bits, T=48), spare (bit 32) and data (32 bits, T=31). A frame is executed only when its request flag is 1 and its node address equals `node_id` or 127.
- R2: An executed read (command 1) puts the bus address on the local bus as a read and returns a reply. The reply has node address 0, request flag 0, and the hop count plus one (saturating). The command, bus address and spare bit are unchanged, and the data field holds the word read.
- R3: An executed write (command 2) drives one bus write of the frame's data to the frame's bus address. A write to this node's own address sends no frame downstream.
- R4: An executed read-broadcast (command 3) always performs the bus read. If bit 0 of the word read is 1, it replies as in R2. Otherwise it forwards the received frame bit for bit.
- R5: An executed bridge command (command 4) loads `bridge` from data bit 0 and makes no bus access. A bridge command to this node's own address sends no frame downstream. `bridge` is 0 after reset.
- R6: An executed no-operation (command 7) forwards the received frame bit for bit.
- R7: Three kinds of frame are forwarded with only the hop count changed, to hop plus one, saturating at 255: a frame for another node, a frame with request flag 0, and an executed frame with an unlisted command. None of these touches the bus or `bridge`.
- R8: An executed write or bridge command sent to address 127 takes effect locally and is also forwarded bit for bit.
- R9: `tx_send` rises with `tx_frame` already valid. It stays high until `tx_ready` is seen low, and then drops. The handshake is complete when `tx_ready` is next seen high. `tx_frame` does not change while `tx_send` is high.
- R10: `rx_ready` is high only while the handler is idle. A frame is taken only when `rx_valid` and `rx_ready` are both high, and `rx_valid` at any other time is ignored. `rx_ready` stays low from acceptance until the handshake of R9 is complete.
- R11: After reset, `rx_ready` is 1 and `tx_send`, `bus_req` and `bridge` are 0.
- R12: The read data on `bus_rdata` is taken one clock after the cycle in which `bus_req` is high with `bus_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_id | input | 7 | This node's ring address |
| rx_valid | input | 1 | Received frame valid strobe |
| rx_frame | input | 69 | Received frame |
| rx_ready | output | 1 | Handler idle, able to take a frame |
| tx_frame | output | 69 | Frame passed downstream |
| tx_send | output | 1 | Send request to the link layer |
| tx_ready | input | 1 | Link layer transmit buffer ready |
| bus_req | output | 1 | Local bus access strobe |
| bus_we | output | 1 | Local bus write (1) or read (0) |
| bus_addr | output | 16 | Local bus address |
| bus_wdata | output | 32 | Local bus write data |
| bus_rdata | input | 32 | Local bus read data |
| bridge | output | 1 | Bridge mode: 1 bridged, 0 serial |

## Verification
The bench builds the block with its default field widths: a 69-bit frame, a 7-bit node address and an 8-bit hop count. With these widths a single injected frame with hop count 255 exercises saturation, and the all-ones address 127 is reachable directly. The bench also changes `node_id` partway through the run. This checks that frames are decoded against the live port value and that the bit-reversed address field is read correctly for a second, asymmetric address pattern.

// File: rtl/rnf_pkg.sv
package rnf_pkg;
    localparam int NA_W    = 7;
    localparam int HOP_W   = 8;
    localparam int CMD_W   = 4;
    localparam int BA_W    = 16;
    localparam int DW      = 32;
    localparam int FRAME_W = NA_W + 1 + HOP_W + CMD_W + BA_W + 1 + DW;

    // top bit position of each field; bit i of a field sits at TOP - i
    localparam int NA_TOP    = FRAME_W - 1;
    localparam int FLAG_POS  = NA_TOP - NA_W;
    localparam int HOP_TOP   = FLAG_POS - 1;
    localparam int CMD_TOP   = HOP_TOP - HOP_W;
    localparam int BA_TOP    = CMD_TOP - CMD_W;
    localparam int SPARE_POS = BA_TOP - BA_W;
    localparam int D_TOP     = SPARE_POS - 1;

    localparam logic [NA_W-1:0] BCAST_ID  = '1;
    localparam logic [NA_W-1:0] MASTER_ID = '0;

    localparam logic [CMD_W-1:0] CMD_READ   = CMD_W'(1);
    localparam logic [CMD_W-1:0] CMD_WRITE  = CMD_W'(2);
    localparam logic [CMD_W-1:0] CMD_RDBC   = CMD_W'(3);
    localparam logic [CMD_W-1:0] CMD_BRIDGE = CMD_W'(4);
    localparam logic [CMD_W-1:0] CMD_NOP    = CMD_W'(7);

    typedef struct packed {
        logic [NA_W-1:0]  node;
        logic             req;
        logic [HOP_W-1:0] hop;
        logic [CMD_W-1:0] cmd;
        logic [BA_W-1:0]  baddr;
        logic             spare;
        logic [DW-1:0]    data;
    } fields_t;

    function automatic logic [HOP_W-1:0] hop_bump(input logic [HOP_W-1:0] h);
        if (&h) return h;
        return h + 1'b1;
    endfunction
endpackage

// File: rtl/rnf_unpack.sv
module rnf_unpack
    import rnf_pkg::*;
(
    input  logic [FRAME_W-1:0] frame_i,
    output fields_t            fields_o
);
    wire [NA_W-1:0]  node_w;
    wire [HOP_W-1:0] hop_w;
    wire [CMD_W-1:0] cmd_w;
    wire [BA_W-1:0]  ba_w;
    wire [DW-1:0]    data_w;

    for (genvar i = 0; i < NA_W; i++) begin : g_node
        assign node_w[i] = frame_i[NA_TOP - i];
    end
    for (genvar i = 0; i < HOP_W; i++) begin : g_hop
        assign hop_w[i] = frame_i[HOP_TOP - i];
    end
    for (genvar i = 0; i < CMD_W; i++) begin : g_cmd
        assign cmd_w[i] = frame_i[CMD_TOP - i];
    end
    for (genvar i = 0; i < BA_W; i++) begin : g_ba
        assign ba_w[i] = frame_i[BA_TOP - i];
    end
    for (genvar i = 0; i < DW; i++) begin : g_data
        assign data_w[i] = frame_i[D_TOP - i];
    end

    assign fields_o = '{node: node_w, req: frame_i[FLAG_POS], hop: hop_w,
                        cmd: cmd_w, baddr: ba_w, spare: frame_i[SPARE_POS],
                        data: data_w};
endmodule

// File: rtl/rnf_pack.sv
module rnf_pack
    import rnf_pkg::*;
(
    input  fields_t            fields_i,
    output wire [FRAME_W-1:0]  frame_o
);
    for (genvar i = 0; i < NA_W; i++) begin : g_node
        assign frame_o[NA_TOP - i] = fields_i.node[i];
    end
    for (genvar i = 0; i < HOP_W; i++) begin : g_hop
        assign frame_o[HOP_TOP - i] = fields_i.hop[i];
    end
    for (genvar i = 0; i < CMD_W; i++) begin : g_cmd
        assign frame_o[CMD_TOP - i] = fields_i.cmd[i];
    end
    for (genvar i = 0; i < BA_W; i++) begin : g_ba
        assign frame_o[BA_TOP - i] = fields_i.baddr[i];
    end
    for (genvar i = 0; i < DW; i++) begin : g_data
        assign frame_o[D_TOP - i] = fields_i.data[i];
    end

    assign frame_o[FLAG_POS]  = fields_i.req;
    assign frame_o[SPARE_POS] = fields_i.spare;
endmodule

// File: rtl/rnf_tx_hs.sv
module rnf_tx_hs (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic tx_ready_i,
    output logic tx_send_o,
    output logic done_o
);
    typedef enum logic [1:0] {
        H_IDLE,
        H_ASSERT,
        H_WAIT
    } hs_state_e;

    hs_state_e st, st_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= H_IDLE;
        else        st <= st_n;
    end

    always_comb begin
        st_n = st;
        unique case (st)
            H_IDLE:   if (start_i)     st_n = H_ASSERT;
            H_ASSERT: if (!tx_ready_i) st_n = H_WAIT;
            H_WAIT:   if (tx_ready_i)  st_n = H_IDLE;
            default:                   st_n = H_IDLE;
        endcase
    end

    always_comb begin
        tx_send_o = 1'b0;
        done_o    = 1'b0;
        unique case (st)
            H_IDLE:   ;
            H_ASSERT: tx_send_o = 1'b1;
            H_WAIT:   done_o    = tx_ready_i;
            default:  ;
        endcase
    end
endmodule

// File: rtl/rnf_core.sv
module rnf_core
    import rnf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NA_W-1:0]  node_id,
    input  logic             rx_valid,
    input  fields_t          rx_f,
    output logic             rx_ready,
    output logic             bus_req,
    output logic             bus_we,
    output logic [BA_W-1:0]  bus_addr,
    output logic [DW-1:0]    bus_wdata,
    input  logic [DW-1:0]    bus_rdata,
    output logic             bridge,
    output fields_t          out_f,
    output logic             hs_start,
    input  logic             hs_done
);
    typedef enum logic [2:0] {
        C_IDLE,
        C_EXEC,
        C_RDWAIT,
        C_LAUNCH,
        C_WAITTX
    } core_state_e;

    core_state_e st, st_n;
    fields_t     req_q;
    fields_t     out_q;
    logic        bridge_q;

    logic hit, bcast, is_read, is_rdbc, is_write, is_bridge, is_nop;
    logic needs_read, consume;
    fields_t fwd_bumped, reply_f;

    always_comb begin
        bcast      = (req_q.node == BCAST_ID);
        hit        = req_q.req && (bcast || (req_q.node == node_id));
        is_read    = hit && (req_q.cmd == CMD_READ);
        is_rdbc    = hit && (req_q.cmd == CMD_RDBC);
        is_write   = hit && (req_q.cmd == CMD_WRITE);
        is_bridge  = hit && (req_q.cmd == CMD_BRIDGE);
        is_nop     = hit && (req_q.cmd == CMD_NOP);
        needs_read = is_read || is_rdbc;
        consume    = (is_write || is_bridge) && !bcast;

        fwd_bumped     = req_q;
        fwd_bumped.hop = hop_bump(req_q.hop);

        reply_f      = req_q;
        reply_f.node = MASTER_ID;
        reply_f.req  = 1'b0;
        reply_f.hop  = hop_bump(req_q.hop);
        reply_f.data = bus_rdata;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= C_IDLE;
        else        st <= st_n;
    end

    // transitions
    always_comb begin
        st_n = st;
        unique case (st)
            C_IDLE:   if (rx_valid) st_n = C_EXEC;
            C_EXEC: begin
                if (needs_read)   st_n = C_RDWAIT;
                else if (consume) st_n = C_IDLE;
                else              st_n = C_LAUNCH;
            end
            C_RDWAIT: st_n = C_LAUNCH;
            C_LAUNCH: st_n = C_WAITTX;
            C_WAITTX: if (hs_done) st_n = C_IDLE;
            default:  st_n = C_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        rx_ready = 1'b0;
        bus_req  = 1'b0;
        bus_we   = 1'b0;
        hs_start = 1'b0;
        unique case (st)
            C_IDLE:   rx_ready = 1'b1;
            C_EXEC: begin
                bus_req = needs_read || is_write;
                bus_we  = is_write;
            end
            C_RDWAIT: ;
            C_LAUNCH: hs_start = 1'b1;
            C_WAITTX: ;
            default:  ;
        endcase
    end

    assign bus_addr  = req_q.baddr;
    assign bus_wdata = req_q.data;

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q    <= '0;
            out_q    <= '0;
            bridge_q <= 1'b0;
        end else begin
            if (st == C_IDLE && rx_valid) req_q <= rx_f;
            if (st == C_EXEC) begin
                if (is_nop || ((is_write || is_bridge) && bcast)) out_q <= req_q;
                else                                              out_q <= fwd_bumped;
                if (is_bridge) bridge_q <= req_q.data[0];
            end
            if (st == C_RDWAIT) begin
                if (is_rdbc && !bus_rdata[0]) out_q <= req_q;
                else                          out_q <= reply_f;
            end
        end
    end

    assign bridge = bridge_q;
    assign out_f  = out_q;
endmodule

// File: rtl/ring_frame_node.sv
module ring_frame_node
    import rnf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NA_W-1:0]    node_id,
    input  logic               rx_valid,
    input  logic [FRAME_W-1:0] rx_frame,
    output logic               rx_ready,
    output logic [FRAME_W-1:0] tx_frame,
    output logic               tx_send,
    input  logic               tx_ready,
    output logic               bus_req,
    output logic               bus_we,
    output logic [BA_W-1:0]    bus_addr,
    output logic [DW-1:0]      bus_wdata,
    input  logic [DW-1:0]      bus_rdata,
    output logic               bridge
);
    fields_t rx_f, out_f;
    logic    hs_start, hs_done;
    wire [FRAME_W-1:0] packed_w;

    rnf_unpack u_unpack (
        .frame_i  (rx_frame),
        .fields_o (rx_f)
    );

    rnf_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .node_id   (node_id),
        .rx_valid  (rx_valid),
        .rx_f      (rx_f),
        .rx_ready  (rx_ready),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bridge    (bridge),
        .out_f     (out_f),
        .hs_start  (hs_start),
        .hs_done   (hs_done)
    );

    rnf_pack u_pack (
        .fields_i (out_f),
        .frame_o  (packed_w)
    );

    rnf_tx_hs u_hs (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (hs_start),
        .tx_ready_i (tx_ready),
        .tx_send_o  (tx_send),
        .done_o     (hs_done)
    );

    assign tx_frame = packed_w;
endmodule

// File: rtl/rnf_node_chk.sv
module rnf_node_chk
    import rnf_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               rx_ready,
    input logic               tx_send,
    input logic               tx_ready,
    input logic [FRAME_W-1:0] tx_frame,
    input logic               bus_req,
    input logic               bridge
);
    assert_send_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_send && tx_ready) |=> tx_send);

    assert_send_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_send && !tx_ready) |=> !tx_send);

    assert_frame_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_send && $past(tx_send)) |-> $stable(tx_frame));

    assert_busy_send_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_send |-> !rx_ready);

    assert_busy_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !rx_ready);

    assert_bridge_nobus_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bridge) |-> (!$past(bus_req) && !$past(rx_ready)));
endmodule

bind ring_frame_node rnf_node_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_ready (rx_ready),
    .tx_send  (tx_send),
    .tx_ready (tx_ready),
    .tx_frame (tx_frame),
    .bus_req  (bus_req),
    .bridge   (bridge)
);

// File: tb/ring_frame_node_tb_top.sv
module ring_frame_node_tb_top;
    import rnf_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [6:0]  node_id = 7'd5;
    logic        rx_valid = 1'b0;
    logic [68:0] rx_frame = '0;
    logic        rx_ready, tx_send, bus_req, bus_we, bridge;
    logic        tx_ready = 1'b1;
    logic [68:0] tx_frame;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;

    always #5 clk = ~clk;

    ring_frame_node dut_i (
        .clk(clk), .rst_n(rst_n), .node_id(node_id),
        .rx_valid(rx_valid), .rx_frame(rx_frame), .rx_ready(rx_ready),
        .tx_frame(tx_frame), .tx_send(tx_send), .tx_ready(tx_ready),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bridge(bridge)
    );

    // local bus model: read data one clock after the request (R12)
    logic [31:0] mem [0:255];
    initial for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    always @(posedge clk) begin
        if (bus_req) begin
            if (bus_we) mem[bus_addr[7:0]] <= bus_wdata;
            else        bus_rdata <= mem[bus_addr[7:0]];
        end
    end

    int checks = 0;
    int fails  = 0;
    int tx_seen = 0;
    bit finished = 1'b0;
    logic [68:0] exp_q [$];
    string       tag_q [$];

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // frame builder from the field positions in R1
    function automatic logic [68:0] mk(input logic [6:0] n, input logic r,
                                       input logic [7:0] h, input logic [3:0] c,
                                       input logic [15:0] a, input logic [31:0] d);
        logic [68:0] f;
        f = '0;
        for (int i = 0; i < 7; i++)  f[68 - i] = n[i];
        f[61] = r;
        for (int i = 0; i < 8; i++)  f[60 - i] = h[i];
        for (int i = 0; i < 4; i++)  f[52 - i] = c[i];
        for (int i = 0; i < 16; i++) f[48 - i] = a[i];
        for (int i = 0; i < 32; i++) f[31 - i] = d[i];
        return f;
    endfunction

    // monitor: link-layer side of the handshake and scoreboard
    initial begin
        logic [68:0] e;
        string t;
        forever begin
            @(negedge clk);
            if (tx_send) begin
                tx_seen++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected downstream frame", tx_frame, 0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(tx_frame === e, t, tx_frame, e);
                end
                repeat (2) @(negedge clk);
                chk(tx_send === 1'b1, "R9 send held while ready high", tx_send, 1);
                tx_ready = 1'b0;
                @(negedge clk);
                chk(tx_send === 1'b0, "R9 send drops after ready low", tx_send, 0);
                repeat (2) @(negedge clk);
                tx_ready = 1'b1;
            end
        end
    end

    task automatic put(input logic [68:0] fr, input bit exp_out,
                       input logic [68:0] ef, input string tag);
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        rx_frame = fr;
        rx_valid = 1'b1;
        if (exp_out) begin
            exp_q.push_back(ef);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        chk(rx_ready === 1'b0, "R10 ready low after accept", rx_ready, 0);
    endtask

    task automatic settle;
        do @(negedge clk); while (!(rx_ready && tx_ready && exp_q.size() == 0));
        repeat (2) @(negedge clk);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R10 watchdog expired act=0 exp=1");
        summary();
    end

    initial begin
        int n0;
        logic [68:0] f;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rx_ready === 1'b1 && tx_send === 1'b0 && bus_req === 1'b0 && bridge === 1'b0,
            "R11 reset state", {rx_ready, tx_send, bus_req, bridge}, 4'b1000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 unicast write, no output
        n0 = tx_seen;
        put(mk(7'd5, 1, 8'd0, 4'h2, 16'h0010, 32'hA5A5_0001), 0, '0, "");
        settle();
        chk(mem[8'h10] === 32'hA5A5_0001, "R3 bus write data", mem[8'h10], 32'hA5A5_0001);
        chk(tx_seen == n0, "R3 no frame after unicast write", tx_seen, n0);

        // R2 / R12 read reply
        put(mk(7'd5, 1, 8'd2, 4'h1, 16'h0010, 32'h0),
            1, mk(7'd0, 0, 8'd3, 4'h1, 16'h0010, 32'hA5A5_0001), "R2 read reply");
        settle();

        // R7 other node
        put(mk(7'd9, 1, 8'd3, 4'h1, 16'h0010, 32'h1111),
            1, mk(7'd9, 1, 8'd4, 4'h1, 16'h0010, 32'h1111), "R7 foreign frame hop+1");
        settle();

        // R7 unlisted command, hop saturation
        put(mk(7'd5, 1, 8'd255, 4'h9, 16'h0010, 32'h2222),
            1, mk(7'd5, 1, 8'd255, 4'h9, 16'h0010, 32'h2222), "R7 unlisted cmd hop saturates");
        settle();

        // R6 NOP
        put(mk(7'd5, 1, 8'd7, 4'h7, 16'h00AB, 32'h3333),
            1, mk(7'd5, 1, 8'd7, 4'h7, 16'h00AB, 32'h3333), "R6 nop unchanged");
        settle();

        // R4 read-broadcast, bit0 set -> reply; clear -> forward unchanged
        put(mk(7'd5, 1, 8'd0, 4'h2, 16'h0020, 32'h0000_0003), 0, '0, "");
        settle();
        put(mk(7'd5, 1, 8'd0, 4'h2, 16'h0021, 32'h0000_0002), 0, '0, "");
        settle();
        put(mk(7'd5, 1, 8'd0, 4'h3, 16'h0020, 32'h0),
            1, mk(7'd0, 0, 8'd1, 4'h3, 16'h0020, 32'h0000_0003), "R4 rdbc bit0=1 replies");
        settle();
        put(mk(7'd5, 1, 8'd6, 4'h3, 16'h0021, 32'h55),
            1, mk(7'd5, 1, 8'd6, 4'h3, 16'h0021, 32'h55), "R4 rdbc bit0=0 forwards unchanged");
        settle();

        // R5 bridge unicast
        n0 = tx_seen;
        put(mk(7'd5, 1, 8'd0, 4'h4, 16'h0010, 32'h0000_0001), 0, '0, "");
        settle();
        chk(bridge === 1'b1, "R5 bridge set", bridge, 1);
        chk(mem[8'h10] === 32'hA5A5_0001, "R5 bridge leaves bus untouched", mem[8'h10], 32'hA5A5_0001);
        put(mk(7'd5, 1, 8'd0, 4'h4, 16'h0010, 32'hFFFF_FFFE), 0, '0, "");
        settle();
        chk(bridge === 1'b0, "R5 bridge cleared", bridge, 0);
        chk(tx_seen == n0, "R5 no frame after unicast bridge", tx_seen, n0);

        // R8 broadcast write and bridge
        f = mk(7'd127, 1, 8'd4, 4'h2, 16'h0030, 32'h0000_1234);
        put(f, 1, f, "R8 broadcast write forwarded");
        settle();
        chk(mem[8'h30] === 32'h0000_1234, "R8 broadcast write executed", mem[8'h30], 32'h1234);
        f = mk(7'd127, 1, 8'd4, 4'h4, 16'h0000, 32'h0000_0001);
        put(f, 1, f, "R8 broadcast bridge forwarded");
        settle();
        chk(bridge === 1'b1, "R8 broadcast bridge executed", bridge, 1);

        // R7 / R1 request flag clear: forwarded, not executed
        put(mk(7'd5, 0, 8'd1, 4'h2, 16'h0010, 32'hDEAD),
            1, mk(7'd5, 0, 8'd2, 4'h2, 16'h0010, 32'hDEAD), "R7 flag-clear frame forwarded");
        settle();
        chk(mem[8'h10] === 32'hA5A5_0001, "R1 flag-clear frame not executed", mem[8'h10], 32'hA5A5_0001);

        // R10 frame presented while busy is ignored
        n0 = tx_seen;
        put(mk(7'd9, 1, 8'd0, 4'h7, 16'h0000, 32'h0),
            1, mk(7'd9, 1, 8'd1, 4'h7, 16'h0000, 32'h0), "R10 busy-case forward");
        rx_frame = mk(7'd5, 1, 8'd0, 4'h2, 16'h0040, 32'hBAD);
        rx_valid = 1'b1;
        repeat (2) @(negedge clk);
        rx_valid = 1'b0;
        settle();
        chk(mem[8'h40] === 32'h0, "R10 busy frame ignored", mem[8'h40], 0);
        chk(tx_seen == n0 + 1, "R10 one frame only", tx_seen, n0 + 1);

        // R1 asymmetric node address via port
        node_id = 7'h12;
        put(mk(7'h12, 1, 8'd9, 4'h1, 16'h0030, 32'h0),
            1, mk(7'd0, 0, 8'd10, 4'h1, 16'h0030, 32'h0000_1234), "R1 new node id read reply");
        settle();
        put(mk(7'd5, 1, 8'd9, 4'h1, 16'h0030, 32'h0),
            1, mk(7'd5, 1, 8'd10, 4'h1, 16'h0030, 32'h0), "R1 old id now foreign");
        settle();

        summary();
    end
endmodule